// File: doc/BRIEF.md
# Receive Frame Queue

This block sits between a receive MAC datapath and a 32-bit host register port. Bytes come in one per cycle with start-of-frame and end-of-frame marks. They are packed into 32-bit words in a data ring. When a frame closes, one 32-bit status word is queued in a separate status ring. That word holds the byte length and the error flags that the upstream logic supplied with the end mark.

The host first sees a count word. Its upper half counts waiting frames and its lower half counts readable data words. The host pops a status word, then pops ceil(length/4) data words. An alert goes high when the number of queued frames reaches a programmable level. A frame that cannot be stored in full is discarded whole and raises a sticky overflow flag. A flush input empties both rings while it is held.

Top module: `rx_frame_queue`

## Requirements
- R1: After reset the count word is zero, both overflow flags are low and the alert is low.
- R2: Bytes are packed little-endian: the first byte of a frame lands in bits 7:0 of its first word. The last word of a frame has zeros in the bytes beyond the frame length.
- R3: A status word is {flags[15:0], length[15:0]}, with the byte length in bits 15:0. `stat_head_err` is high when the head status word has any bit set under mask 0xDF180000.
- R4: `count_word` bits 31:16 give the number of queued status words. Bits 15:0 give the number of data words the host may pop.
- R5: A frame's data words and its status word become visible together, in the cycle after the clock edge that takes its end byte. A partly received frame adds nothing to the count word.
- R6: `stat_pop` removes the head status word and `data_pop` removes the head data word. A pop on an empty ring has no effect.
- R7: `af_irq` is high while `af_level` is nonzero and the queued frame count is at least `af_level`. `af_level` of zero keeps it low.
- R8: If a frame does not fit in the data ring, all of its words are discarded and `data_ovf` goes high and stays high. Frames already queued are untouched.
- R9: If a frame ends while the status ring is full, the frame is discarded whole and `stat_ovf` goes high and stays high.
- R10: While `flush` is high, both rings are emptied, a frame in progress is abandoned, both overflow flags clear, and input bytes and pops are ignored.
- R11: A start mark inside an open frame abandons the partial frame without raising a flag. Bytes that arrive with no frame open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte strobe from the receive datapath |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_flags | input | 16 | Frame status flags, sampled with the end byte |
| flush | input | 1 | Empties both rings while high |
| af_level | input | 16 | Frame-count alert level, zero disables |
| stat_pop | input | 1 | Pop head status word |
| data_pop | input | 1 | Pop head data word |
| stat_head | output | 32 | Head of the status ring |
| stat_head_err | output | 1 | Head status word marks a receive error |
| data_head | output | 32 | Head of the data ring |
| count_word | output | 32 | {queued frames, readable data words} |
| af_irq | output | 1 | Frame-count alert |
| stat_ovf | output | 1 | Sticky status-ring overflow |
| data_ovf | output | 1 | Sticky data-ring overflow |

## Verification
Suppose the speculative or committed pointers were wrong. Then the lower half of the count word would be off in the very cycle after the affected end byte, or after the restart or drop. The next data pop would also show a shifted or stale word at `data_head`. Packing errors show up at `data_head` as soon as a frame is committed. Missed rollbacks show up as extra words on the next frame. A wrong full decision shows up as a wrong overflow flag one cycle after the end byte. A reference model compared every cycle catches each of these within one clock of where it first becomes visible.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam logic [31:0] RX_ERR_MASK = 32'hDF18_0000;

  // place a byte into its lane of a partly built word
  function automatic logic [31:0] lane_insert(input logic [31:0] base,
                                              input logic [1:0]  lane,
                                              input logic [7:0]  b);
    return base | (32'(b) << {lane, 3'b000});
  endfunction

  function automatic logic [31:0] make_status(input logic [15:0] flags,
                                              input logic [15:0] len);
    return {flags, len};
  endfunction

  function automatic logic status_is_error(input logic [31:0] w);
    return |(w & RX_ERR_MASK);
  endfunction

  function automatic logic [31:0] make_count(input logic [15:0] frames,
                                             input logic [15:0] words);
    return {frames, words};
  endfunction
endpackage

// File: rtl/rxq_ring.sv
// Ring buffer with a speculative write pointer that can be committed or
// rolled back to the last committed position. DEPTH must be a power of two.
module rxq_ring #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_val,
  input  logic          rollback,
  input  logic          commit,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [PW-1:0] commit_cnt,
  output logic [PW-1:0] spec_cnt
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sptr, cptr, rptr;
  logic [PW-1:0] spec_base, spec_nxt;
  logic          pop_ok;

  assign spec_base = rollback ? cptr : sptr;
  assign spec_nxt  = spec_base + PW'(push);
  assign pop_ok    = pop && (cptr != rptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sptr <= '0;
      cptr <= '0;
      rptr <= '0;
    end else if (flush) begin
      sptr <= '0;
      cptr <= '0;
      rptr <= '0;
    end else begin
      sptr <= spec_nxt;
      if (commit) cptr <= spec_nxt;
      if (pop_ok) rptr <= rptr + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[spec_base[AW-1:0]] <= push_val;
  end

  assign head       = mem[rptr[AW-1:0]];
  assign commit_cnt = cptr - rptr;
  assign spec_cnt   = sptr - rptr;
endmodule

// File: rtl/rxq_packer.sv
// Packs received bytes into little-endian 32-bit words and tracks frame length.
module rxq_packer
  import rxq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  output logic        word_we,
  output logic [31:0] word_val,
  output logic        frame_begin,
  output logic        restart,
  output logic        frame_end,
  output logic [15:0] frame_len
);
  logic        in_frame;
  logic [1:0]  lane;
  logic [15:0] len_q;
  logic [31:0] acc;
  logic        byte_ok;
  logic [1:0]  cur_lane;

  assign byte_ok     = rx_valid && (rx_sof || in_frame) && !flush;
  assign cur_lane    = rx_sof ? 2'd0 : lane;
  assign frame_len   = rx_sof ? 16'd1 : len_q + 16'd1;
  assign word_val    = lane_insert(rx_sof ? 32'd0 : acc, cur_lane, rx_data);
  assign word_we     = byte_ok && (cur_lane == 2'd3 || rx_eof);
  assign frame_begin = byte_ok && rx_sof;
  assign restart     = byte_ok && rx_sof && in_frame;
  assign frame_end   = byte_ok && rx_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      lane     <= '0;
      len_q    <= '0;
      acc      <= '0;
    end else if (flush) begin
      in_frame <= 1'b0;
      lane     <= '0;
      len_q    <= '0;
      acc      <= '0;
    end else if (byte_ok) begin
      in_frame <= !rx_eof;
      lane     <= cur_lane + 2'd1;
      len_q    <= frame_len;
      acc      <= (cur_lane == 2'd3) ? 32'd0 : word_val;
    end
  end
endmodule

// File: rtl/rx_frame_queue.sv
module rx_frame_queue
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_DEPTH = 32,
  parameter int unsigned STAT_DEPTH = 4,
  localparam int unsigned DPW = $clog2(DATA_DEPTH) + 1,
  localparam int unsigned SPW = $clog2(STAT_DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [15:0] rx_flags,
  input  logic        flush,
  input  logic [15:0] af_level,
  input  logic        stat_pop,
  input  logic        data_pop,
  output logic [31:0] stat_head,
  output logic        stat_head_err,
  output logic [31:0] data_head,
  output logic [31:0] count_word,
  output logic        af_irq,
  output logic        stat_ovf,
  output logic        data_ovf
);
  logic        word_we, frame_begin, restart, frame_end;
  logic [31:0] word_val;
  logic [15:0] frame_len;
  logic [DPW-1:0] d_commit_cnt, d_spec_cnt, d_base;
  logic [SPW-1:0] s_commit_cnt, s_spec_cnt;
  logic lost_q, lost_cur, word_lost, lost_now, s_full;
  logic d_push, d_rollback;
  // named events observed by the checker
  logic frame_accept, frame_drop;

  rxq_packer u_pack (
    .clk, .rst_n, .flush, .rx_valid, .rx_data, .rx_sof, .rx_eof,
    .word_we, .word_val, .frame_begin, .restart, .frame_end, .frame_len
  );

  assign lost_cur     = frame_begin ? 1'b0 : lost_q;
  assign d_base       = restart ? d_commit_cnt : d_spec_cnt;
  assign word_lost    = word_we && (lost_cur || d_base >= DPW'(DATA_DEPTH));
  assign lost_now     = lost_cur || word_lost;
  assign s_full       = s_spec_cnt >= SPW'(STAT_DEPTH);
  assign frame_accept = frame_end && !lost_now && !s_full;
  assign frame_drop   = frame_end && !frame_accept;
  assign d_push       = word_we && !word_lost && !frame_drop;
  assign d_rollback   = restart || frame_drop;

  rxq_ring #(.DEPTH(DATA_DEPTH), .W(32)) u_data (
    .clk, .rst_n, .flush,
    .push(d_push), .push_val(word_val), .rollback(d_rollback),
    .commit(frame_accept), .pop(data_pop),
    .head(data_head), .commit_cnt(d_commit_cnt), .spec_cnt(d_spec_cnt)
  );

  rxq_ring #(.DEPTH(STAT_DEPTH), .W(32)) u_stat (
    .clk, .rst_n, .flush,
    .push(frame_accept), .push_val(make_status(rx_flags, frame_len)),
    .rollback(1'b0), .commit(frame_accept), .pop(stat_pop),
    .head(stat_head), .commit_cnt(s_commit_cnt), .spec_cnt(s_spec_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q   <= 1'b0;
      stat_ovf <= 1'b0;
      data_ovf <= 1'b0;
    end else if (flush) begin
      lost_q   <= 1'b0;
      stat_ovf <= 1'b0;
      data_ovf <= 1'b0;
    end else begin
      if (frame_end) lost_q <= 1'b0;
      else if (frame_begin || word_we) lost_q <= lost_now;
      if (frame_drop) begin
        if (lost_now) data_ovf <= 1'b1;
        if (s_full)   stat_ovf <= 1'b1;
      end
    end
  end

  assign stat_head_err = status_is_error(stat_head);
  assign count_word    = make_count(16'(s_commit_cnt), 16'(d_commit_cnt));
  assign af_irq        = (af_level != 16'd0) && (16'(s_commit_cnt) >= af_level);
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned DATA_DEPTH = 32,
  parameter int unsigned STAT_DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_eof,
  input logic        flush,
  input logic [31:0] count_word,
  input logic        stat_ovf,
  input logic        data_ovf,
  input logic        frame_accept,
  input logic        frame_drop
);
  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_word[31:16] <= 16'(STAT_DEPTH)) && (count_word[15:0] <= 16'(DATA_DEPTH)));

  // R5
  frame_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_word[31:16] > $past(count_word[31:16])) |-> $past(rx_valid && rx_eof && frame_accept));

  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count_word == 32'd0) && !stat_ovf && !data_ovf);

  // R9
  sovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_ovf) |-> ($past(count_word[31:16]) == 16'(STAT_DEPTH)) && $past(frame_drop));

  // R8
  dovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ovf) |-> count_word[31:16] <= $past(count_word[31:16]));
endmodule

bind rx_frame_queue rxq_checker #(.DATA_DEPTH(DATA_DEPTH), .STAT_DEPTH(STAT_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof), .flush(flush),
  .count_word(count_word), .stat_ovf(stat_ovf), .data_ovf(data_ovf),
  .frame_accept(frame_accept), .frame_drop(frame_drop)
);

// File: tb/rx_frame_queue_test.sv
`timescale 1ns/1ps
module rx_frame_queue_test;
  localparam int DDEP = 32;
  localparam int SDEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, flush = 0, stat_pop = 0, data_pop = 0;
  logic [7:0]  rx_data = 0;
  logic [15:0] rx_flags = 0, af_level = 0;
  logic [31:0] stat_head, data_head, count_word;
  logic stat_head_err, af_irq, stat_ovf, data_ovf;

  always #4 clk = ~clk;

  rx_frame_queue #(.DATA_DEPTH(DDEP), .STAT_DEPTH(SDEP)) uut (
    .clk, .rst_n, .rx_valid, .rx_data, .rx_sof, .rx_eof, .rx_flags, .flush,
    .af_level, .stat_pop, .data_pop, .stat_head, .stat_head_err, .data_head,
    .count_word, .af_irq, .stat_ovf, .data_ovf
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  logic [31:0] dq[$], sq[$], pend[$];
  bit m_in = 0, m_lost = 0, m_dovf = 0, m_sovf = 0;
  int m_lane = 0, m_len = 0;
  logic [31:0] m_acc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    int dsz = dq.size();
    int ssz = sq.size();
    if (flush) begin
      dq.delete(); sq.delete(); pend.delete();
      m_in = 0; m_lost = 0; m_dovf = 0; m_sovf = 0; m_lane = 0; m_acc = 0; m_len = 0;
      return;
    end
    if (rx_valid && (rx_sof || m_in)) begin
      if (rx_sof) begin pend.delete(); m_lost = 0; m_lane = 0; m_acc = 0; m_len = 0; end
      m_acc = m_acc | (32'(rx_data) << (8 * m_lane));
      m_len++;
      if (m_lane == 3 || rx_eof) begin
        if (m_lost || (dsz + pend.size()) >= DDEP) m_lost = 1;
        else pend.push_back(m_acc);
        m_acc = 0;
      end
      m_lane = (m_lane + 1) % 4;
      if (rx_eof) begin
        if (m_lost || ssz >= SDEP) begin
          if (m_lost) m_dovf = 1;
          if (ssz >= SDEP) m_sovf = 1;
        end else begin
          foreach (pend[i]) dq.push_back(pend[i]);
          sq.push_back({rx_flags, 16'(m_len)});
        end
        pend.delete(); m_in = 0; m_lost = 0; m_lane = 0; m_acc = 0;
      end else m_in = 1;
    end
    if (stat_pop && ssz > 0) void'(sq.pop_front());
    if (data_pop && dsz > 0) void'(dq.pop_front());
  endtask

  task automatic compare();
    logic [31:0] ec = {16'(sq.size()), 16'(dq.size())};
    bit ea = (af_level != 0) && (sq.size() >= int'(af_level));
    chk(count_word === ec, "R4 count word", count_word, ec);
    chk(af_irq === ea, "R7 alert", 32'(af_irq), 32'(ea));
    chk(data_ovf === m_dovf, "R8 data overflow flag", 32'(data_ovf), 32'(m_dovf));
    chk(stat_ovf === m_sovf, "R9 status overflow flag", 32'(stat_ovf), 32'(m_sovf));
    if (sq.size() > 0) begin
      chk(stat_head === sq[0], "R3 status head", stat_head, sq[0]);
      chk(stat_head_err === |(sq[0] & 32'hDF180000), "R3 error mark",
          32'(stat_head_err), 32'(|(sq[0] & 32'hDF180000)));
    end
    if (dq.size() > 0) chk(data_head === dq[0], "R2 data head", data_head, dq[0]);
  endtask

  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  task automatic idle(input int n);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; stat_pop = 0; data_pop = 0; flush = 0;
    repeat (n) tick();
  endtask

  task automatic send_frame(input int len, input int base, input logic [15:0] fl);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = 8'(base + i); rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_flags = fl;
      tick();
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
  endtask

  task automatic drain();
    stat_pop = 1; data_pop = 1;
    while (sq.size() > 0 || dq.size() > 0) tick();
    stat_pop = 0; data_pop = 0;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(count_word === 0 && !stat_ovf && !data_ovf && !af_irq, "R1 reset state",
        {count_word[31:4], af_irq, stat_ovf, data_ovf, 1'b0}, 32'd0);

    // R6 pops on empty rings
    stat_pop = 1; data_pop = 1; tick(); tick();
    chk(count_word === 0, "R6 pop on empty", count_word, 0);
    idle(1);

    // R11 stray bytes without a start mark
    rx_valid = 1; rx_data = 8'hAA; tick(); rx_eof = 1; tick();
    chk(count_word === 0, "R11 stray bytes ignored", count_word, 0);
    idle(1);

    // R5 partial frame invisible
    rx_valid = 1; rx_sof = 1; rx_data = 8'h01; tick(); rx_sof = 0;
    for (int i = 2; i <= 6; i++) begin rx_data = 8'(i); tick(); end
    chk(count_word === 0, "R5 partial frame not counted", count_word, 0);
    rx_data = 8'h07; rx_eof = 1; tick(); rx_valid = 0; rx_eof = 0;
    chk(count_word === {16'd1, 16'd2}, "R5 frame visible after end", count_word, {16'd1, 16'd2});
    drain();

    // R2 packing and padding
    send_frame(5, 8'h11, 16'h0000);
    chk(data_head === 32'h14131211, "R2 first word little-endian", data_head, 32'h14131211);
    chk(stat_head === 32'h0000_0005, "R3 length field", stat_head, 32'h5);
    data_pop = 1; tick(); data_pop = 0;
    chk(data_head === 32'h0000_0015, "R2 last word zero padded", data_head, 32'h15);
    drain();

    // R3 error marks
    send_frame(3, 8'h40, 16'h0008);
    chk(stat_head === 32'h0008_0003 && stat_head_err, "R3 flagged error", stat_head, 32'h0008_0003);
    stat_pop = 1; data_pop = 1; tick(); stat_pop = 0; data_pop = 0;
    send_frame(4, 8'h50, 16'h2000);
    chk(stat_head_err === 1'b0, "R3 flag outside mask", 32'(stat_head_err), 0);
    drain();

    // R7 alert level
    af_level = 16'd2;
    send_frame(2, 8'h60, 0);
    chk(af_irq === 1'b0, "R7 below level", 32'(af_irq), 0);
    send_frame(6, 8'h70, 0);
    chk(af_irq === 1'b1, "R7 at level", 32'(af_irq), 1);
    af_level = 0; tick();
    chk(af_irq === 1'b0, "R7 zero level disables", 32'(af_irq), 0);
    drain();

    // R9 status ring overflow
    for (int f = 0; f < SDEP; f++) send_frame(1 + f, 8'h80 + 16 * f, 16'(f));
    send_frame(2, 8'hF0, 0);
    chk(stat_ovf === 1'b1 && count_word[31:16] == SDEP, "R9 fifth frame dropped",
        count_word, {16'(SDEP), count_word[15:0]});
    drain();

    // R8 data ring overflow, earlier frame kept
    send_frame(4, 8'h01, 0);
    send_frame(4 * DDEP, 8'h10, 0);
    chk(data_ovf === 1'b1 && count_word === {16'd1, 16'd1}, "R8 oversize frame dropped",
        count_word, {16'd1, 16'd1});
    chk(data_head === 32'h04030201, "R8 earlier data intact", data_head, 32'h04030201);
    send_frame(9, 8'h30, 0);
    chk(count_word === {16'd2, 16'd4}, "R8 next frame stored", count_word, {16'd2, 16'd4});

    // R10 flush mid-frame with content
    rx_valid = 1; rx_sof = 1; rx_data = 8'h99; tick(); rx_sof = 0; tick();
    flush = 1; tick(); tick(); flush = 0;
    chk(count_word === 0 && !data_ovf, "R10 flush empties", count_word, 0);
    rx_data = 8'h98; rx_eof = 1; tick(); rx_valid = 0; rx_eof = 0;
    chk(count_word === 0, "R10 abandoned frame stays out", count_word, 0);
    idle(1);

    // R11 restart inside a frame
    rx_valid = 1; rx_sof = 1; rx_data = 8'hC0; tick(); rx_sof = 0;
    for (int i = 1; i < 6; i++) begin rx_data = 8'(8'hC0 + i); tick(); end
    send_frame(3, 8'hD0, 0);
    chk(count_word === {16'd1, 16'd1} && data_head === 32'h00D2D1D0 && !data_ovf,
        "R11 restart discards partial", data_head, 32'h00D2D1D0);
    drain();

    // mixed traffic with concurrent pops
    for (int k = 0; k < 20; k++) begin
      send_frame(1 + (k * 7) % 23, k * 13, 16'(k * 4099));
      stat_pop = k[0]; data_pop = 1; tick(); tick(); stat_pop = 0; data_pop = 0;
    end
    drain();
    idle(2);
    finish_run();
  end
endmodule